// File: doc/BRIEF.md
# CPU-to-ISA I/O Window Address Translator

This block sits between a CPU memory bus and a 16-bit ISA-style I/O port bus. CPU accesses that land in an 8 MB memory window are claimed and turned into a single port-bus transaction. The port address comes from the window offset by one of two mappings. In contiguous mode the low 16 offset bits are used directly. In non-contiguous mode every 4 KB page of the window exposes 32 ports: the page number is packed above the low five offset bits, and the rest of the page aliases onto those 32 ports.

Byte, halfword and word accesses share one translated address. Write data and read data pass through in little-endian lane order, so lane 0 carries the byte at the lowest address. A single-bit map-type input picks the mapping. It is registered inside the block, and the registered copy clears to contiguous mode on reset. A request that misses the window is not forwarded. It is answered with an all-ones read value.

The controller is a four-state machine:
- IDLE waits for a request.
- ISSUE drives the port strobe for one cycle.
- RESP returns the captured data with a done pulse.
- MISS answers a request outside the window.

The transitions are:
- IDLE to ISSUE when an accepted request hits the window.
- IDLE to MISS when an accepted request misses the window.
- ISSUE to RESP unconditionally.
- RESP to IDLE and MISS to IDLE unconditionally.

Top module: `isa_io_window_xlat`

## Requirements
- R1: A request is claimed and causes exactly one port strobe only when its address lies in [0x80000000, 0x80800000). Any other address causes no strobe.
- R2: With the registered map-type bit at 0 (contiguous), port_addr equals the window offset masked to its low 16 bits.
- R3: With the registered map-type bit at 1 (non-contiguous), port_addr equals (offset & 0x1F) | ((offset & 0x7FF000) >> 7).
- R4: In non-contiguous mode, offset bits 5 to 11 have no effect on port_addr, so two addresses that differ only in those bits reach the same port.
- R5: The registered map-type bit is 0 after reset and takes the map_sel value with one cycle of latency. A request accepted on the first edge after reset uses contiguous mode even if map_sel is 1.
- R6: During the strobe, port_size, port_write and port_wdata equal the accepted request's size, direction and data. The address is the same for every size. Size encoding: 0 = byte, 1 = halfword, 2 or 3 = word.
- R7: For a claimed request, port_stb is high for exactly the one cycle after the accepting edge. rsp_done is high for exactly the cycle after that.
- R8: A claimed read returns port_rdata in little-endian lane order, zero-extended by size: byte keeps bits 7:0, halfword keeps bits 15:0, word keeps all 32 bits. A claimed write returns 0.
- R9: A request outside the window gets rsp_done in the cycle right after the accepting edge, with rsp_rdata = 0xFFFFFFFF and no port strobe.
- R10: Requests presented while a transaction is in progress (ISSUE, RESP or MISS) are ignored and never produce a strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| map_sel | input | 1 | Map-type select: 0 contiguous, 1 non-contiguous |
| req_valid | input | 1 | Request strobe, sampled in IDLE |
| req_addr | input | 32 | CPU address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | Access size code |
| req_wdata | input | 32 | Write data, little-endian lanes |
| port_stb | output | 1 | Port-bus strobe, one cycle |
| port_write | output | 1 | Port-bus direction |
| port_addr | output | 16 | Translated port address |
| port_size | output | 2 | Port-bus access size |
| port_wdata | output | 32 | Port-bus write data |
| port_rdata | input | 32 | Port-bus read data, valid while port_stb is high |
| rsp_done | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Returned read data |

## Verification
The bench sweeps many window offsets in both mapping modes for every size and compares each port address with the arithmetic formula. A design that swapped page and port bits, or shifted by the wrong amount, fails at once. The window edges and addresses just beyond them are probed, so an off-by-one comparator would either claim a neighbour address or drop the last byte of the window. Pairs of addresses that differ only in bits 5 to 11 expose a non-contiguous mapping that leaks those bits. A request presented on the very first edge after reset, with map_sel already high, catches a mode register that resets to the wrong value or has no latency. Requests held high through ISSUE and RESP catch a controller that accepts new work while busy. Byte and halfword reads catch unmasked upper lanes.

// File: rtl/isa_xlat_pkg.sv
package isa_xlat_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_RESP  = 2'd2,
        ST_MISS  = 2'd3
    } xlat_state_e;

    localparam logic [1:0] SZ_BYTE = 2'd0;
    localparam logic [1:0] SZ_HALF = 2'd1;

endpackage

// File: rtl/isa_xlat_map.sv
module isa_xlat_map #(
    parameter int          AW       = 32,
    parameter int          PORT_W   = 16,
    parameter int          SPAN_LG2 = 23,
    parameter int          PAGE_LG2 = 12,
    parameter int          PORT_LG2 = 5,
    parameter logic [31:0] WIN_BASE = 32'h8000_0000
) (
    input  logic [AW-1:0]     addr,
    input  logic              noncontig,
    output logic              hit,
    output logic [PORT_W-1:0] port_addr
);
    localparam int PAGE_BITS = SPAN_LG2 - PAGE_LG2;
    localparam int NC_W      = PAGE_BITS + PORT_LG2;

    logic [SPAN_LG2-1:0] offset;
    logic [NC_W-1:0]     nc_full;
    logic [PORT_W-1:0]   nc_addr;
    logic [PORT_W-1:0]   ct_addr;

    assign offset  = addr[SPAN_LG2-1:0];
    assign hit     = (addr[AW-1:SPAN_LG2] == WIN_BASE[AW-1:SPAN_LG2]);
    assign ct_addr = offset[PORT_W-1:0];
    assign nc_full = {offset[SPAN_LG2-1:PAGE_LG2], offset[PORT_LG2-1:0]};

    generate
        if (NC_W >= PORT_W) begin : g_nc_trunc
            assign nc_addr = nc_full[PORT_W-1:0];
        end else begin : g_nc_pad
            assign nc_addr = {{(PORT_W-NC_W){1'b0}}, nc_full};
        end
    endgenerate

    assign port_addr = noncontig ? nc_addr : ct_addr;

    always_comb begin
        if (noncontig) begin
            AST_NC_LOW_BITS: assert (port_addr[PORT_LG2-1:0] == addr[PORT_LG2-1:0]); // R3
        end
    end
endmodule

// File: rtl/isa_xlat_rdfmt.sv
module isa_xlat_rdfmt #(
    parameter int DW = 32
) (
    input  logic [1:0]    size,
    input  logic          is_write,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout
);
    import isa_xlat_pkg::*;

    always_comb begin
        dout = din;
        if (is_write) begin
            dout = '0;
        end else begin
            unique case (size)
                SZ_BYTE: dout = {{(DW-8){1'b0}}, din[7:0]};
                SZ_HALF: dout = {{(DW-16){1'b0}}, din[15:0]};
                default: dout = din;
            endcase
        end
    end
endmodule

// File: rtl/isa_xlat_ctrl.sv
module isa_xlat_ctrl #(
    parameter int DW     = 32,
    parameter int PORT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sel,
    output logic              mode_q,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [DW-1:0]     req_wdata,
    input  logic              win_hit,
    input  logic [PORT_W-1:0] xlat_addr,
    input  logic [DW-1:0]     fmt_rdata,
    output logic              port_stb,
    output logic              port_write,
    output logic [PORT_W-1:0] port_addr,
    output logic [1:0]        port_size,
    output logic [DW-1:0]     port_wdata,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata
);
    import isa_xlat_pkg::*;

    xlat_state_e state_q, state_d;
    logic        accept;

    assign accept = (state_q == ST_IDLE) && req_valid;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (req_valid) state_d = win_hit ? ST_ISSUE : ST_MISS;
            ST_ISSUE: state_d = ST_RESP;
            ST_RESP:  state_d = ST_IDLE;
            ST_MISS:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= 1'b0;
        else        mode_q <= map_sel;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            port_addr  <= '0;
            port_size  <= '0;
            port_write <= 1'b0;
            port_wdata <= '0;
            rsp_rdata  <= '0;
        end else begin
            if (accept) begin
                port_addr  <= xlat_addr;
                port_size  <= req_size;
                port_write <= req_write;
                port_wdata <= req_wdata;
                if (!win_hit) rsp_rdata <= '1;
            end
            if (state_q == ST_ISSUE) rsp_rdata <= fmt_rdata;
        end
    end

    always_comb begin
        port_stb = 1'b0;
        rsp_done = 1'b0;
        unique case (state_q)
            ST_ISSUE: port_stb = 1'b1;
            ST_RESP:  rsp_done = 1'b1;
            ST_MISS:  rsp_done = 1'b1;
            default:  ;
        endcase
    end

    AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        port_stb |=> !port_stb); // R7
    AST_DONE_AFTER_STB: assert property (@(posedge clk) disable iff (!rst_n)
        port_stb |=> rsp_done); // R7
    AST_MISS_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !win_hit && !port_stb && !rsp_done) |=> (!port_stb && rsp_done && rsp_rdata == '1)); // R9
    AST_BUSY_NO_STB: assert property (@(posedge clk) disable iff (!rst_n)
        (port_stb || rsp_done) |=> !port_stb); // R10
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done); // R7
endmodule

// File: rtl/isa_io_window_xlat.sv
module isa_io_window_xlat #(
    parameter int          DW       = 32,
    parameter int          AW       = 32,
    parameter int          PORT_W   = 16,
    parameter int          SPAN_LG2 = 23,
    parameter int          PAGE_LG2 = 12,
    parameter int          PORT_LG2 = 5,
    parameter logic [31:0] WIN_BASE = 32'h8000_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              map_sel,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_addr,
    input  logic              req_write,
    input  logic [1:0]        req_size,
    input  logic [DW-1:0]     req_wdata,
    output logic              port_stb,
    output logic              port_write,
    output logic [PORT_W-1:0] port_addr,
    output logic [1:0]        port_size,
    output logic [DW-1:0]     port_wdata,
    input  logic [DW-1:0]     port_rdata,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata
);
    logic              mode_q;
    logic              win_hit;
    logic [PORT_W-1:0] xlat_addr;
    logic [DW-1:0]     fmt_rdata;

    isa_xlat_map #(
        .AW(AW), .PORT_W(PORT_W), .SPAN_LG2(SPAN_LG2),
        .PAGE_LG2(PAGE_LG2), .PORT_LG2(PORT_LG2), .WIN_BASE(WIN_BASE)
    ) u_map (
        .addr      (req_addr),
        .noncontig (mode_q),
        .hit       (win_hit),
        .port_addr (xlat_addr)
    );

    isa_xlat_rdfmt #(.DW(DW)) u_rdfmt (
        .size     (port_size),
        .is_write (port_write),
        .din      (port_rdata),
        .dout     (fmt_rdata)
    );

    isa_xlat_ctrl #(.DW(DW), .PORT_W(PORT_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .map_sel    (map_sel),
        .mode_q     (mode_q),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_size   (req_size),
        .req_wdata  (req_wdata),
        .win_hit    (win_hit),
        .xlat_addr  (xlat_addr),
        .fmt_rdata  (fmt_rdata),
        .port_stb   (port_stb),
        .port_write (port_write),
        .port_addr  (port_addr),
        .port_size  (port_size),
        .port_wdata (port_wdata),
        .rsp_done   (rsp_done),
        .rsp_rdata  (rsp_rdata)
    );
endmodule

// File: tb/isa_io_window_xlat_bench.sv
module isa_io_window_xlat_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        map_sel = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic        port_stb, port_write, rsp_done;
    logic [15:0] port_addr;
    logic [1:0]  port_size;
    logic [31:0] port_wdata, port_rdata, rsp_rdata;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    // downstream device model: data derived from the port address
    assign port_rdata = {port_addr ^ 16'hA5C3, ~port_addr};

    isa_io_window_xlat u_isa_io_window_xlat (
        .clk(clk), .rst_n(rst_n), .map_sel(map_sel), .req_valid(req_valid),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_wdata(req_wdata), .port_stb(port_stb), .port_write(port_write),
        .port_addr(port_addr), .port_size(port_size), .port_wdata(port_wdata),
        .port_rdata(port_rdata), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_port(input logic [31:0] a, input logic m);
        logic [31:0] off;
        off = a - 32'h8000_0000;
        if (m) return 16'((off & 32'h1F) | ((off & 32'h7FF000) >> 7));
        return 16'(off & 32'hFFFF);
    endfunction

    function automatic logic [31:0] exp_rd(input logic [15:0] p, input logic [1:0] sz, input logic wr);
        logic [31:0] d;
        d = {p ^ 16'hA5C3, ~p};
        if (wr) return 32'h0;
        if (sz == 2'd0) return d & 32'hFF;
        if (sz == 2'd1) return d & 32'hFFFF;
        return d;
    endfunction

    // one full transaction; the mode is set a cycle ahead so its register settles
    task automatic do_req(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                          input logic [31:0] wd, input logic m);
        logic        hit;
        logic [15:0] ep;
        hit = (a >= 32'h8000_0000) && (a < 32'h8080_0000);
        ep  = exp_port(a, m);
        @(negedge clk);
        map_sel = m;
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        if (hit) begin
            chk(port_stb == 1'b1, "R1 strobe on window hit", 32'(port_stb), 32'd1);
            if (m) chk(port_addr == ep, "R3 non-contiguous port address", 32'(port_addr), 32'(ep));
            else   chk(port_addr == ep, "R2 contiguous port address", 32'(port_addr), 32'(ep));
            chk(port_size == sz && port_write == wr, "R6 size and direction",
                {29'd0, port_write, port_size}, {29'd0, wr, sz});
            chk(port_wdata == wd, "R6 write data", port_wdata, wd);
            chk(rsp_done == 1'b0, "R7 no done during strobe", 32'(rsp_done), 32'd0);
            @(negedge clk);
            chk(port_stb == 1'b0, "R7 strobe lasts one cycle", 32'(port_stb), 32'd0);
            chk(rsp_done == 1'b1, "R7 done after strobe", 32'(rsp_done), 32'd1);
            chk(rsp_rdata == exp_rd(ep, sz, wr), "R8 returned data", rsp_rdata, exp_rd(ep, sz, wr));
        end else begin
            chk(port_stb == 1'b0, "R9 no strobe on miss", 32'(port_stb), 32'd0);
            chk(rsp_done == 1'b1, "R9 immediate done on miss", 32'(rsp_done), 32'd1);
            chk(rsp_rdata == 32'hFFFF_FFFF, "R9 all-ones on miss", rsp_rdata, 32'hFFFF_FFFF);
        end
        @(negedge clk);
        chk(rsp_done == 1'b0 && port_stb == 1'b0, "R7 back to idle",
            {30'd0, port_stb, rsp_done}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [15:0] pa, pb;
        map_sel = 1'b1;
        repeat (3) @(negedge clk);
        chk(port_stb == 1'b0 && rsp_done == 1'b0, "R7 reset outputs idle",
            {30'd0, port_stb, rsp_done}, 32'd0);
        // R5: request on the first edge after reset uses contiguous mode
        rst_n = 1'b1;
        req_valid = 1'b1; req_addr = 32'h8012_3456; req_write = 1'b0; req_size = 2'd2;
        @(negedge clk);
        req_valid = 1'b0;
        chk(port_stb == 1'b1 && port_addr == 16'h3456, "R5 contiguous after reset",
            32'(port_addr), 32'h3456);
        repeat (2) @(negedge clk);
        // R5: after a cycle the registered mode has picked up map_sel=1
        do_req(32'h8012_3456, 1'b0, 2'd2, 32'h0, 1'b1);

        // sweep both modes, all sizes, many offsets
        for (int m = 0; m < 2; m++) begin
            for (int i = 0; i < 48; i++) begin
                for (int s = 0; s < 3; s++) begin
                    logic [31:0] off;
                    off = ((i * 32'h0001_33A7) ^ (i << 17) ^ (s << 9)) & 32'h007F_FFFF;
                    do_req(32'h8000_0000 | off, 1'(i & 1), 2'(s),
                           (i * 32'h0101_0101) ^ 32'hDEAD_BEEF ^ s, 1'(m));
                end
            end
        end

        // window edges and neighbours
        for (int m = 0; m < 2; m++) begin
            do_req(32'h8000_0000, 1'b0, 2'd0, 32'h0, 1'(m));
            do_req(32'h807F_FFFF, 1'b0, 2'd1, 32'h0, 1'(m));
            do_req(32'h807F_FFFF, 1'b0, 2'd3, 32'h0, 1'(m));
            do_req(32'h7FFF_FFFF, 1'b0, 2'd2, 32'h0, 1'(m));
            do_req(32'h8080_0000, 1'b1, 2'd2, 32'h1234, 1'(m));
            do_req(32'h0000_0000, 1'b0, 2'd0, 32'h0, 1'(m));
            do_req(32'hFFFF_FFFF, 1'b0, 2'd2, 32'h0, 1'(m));
        end

        // R4: aliases differing only in bits 5..11 reach the same port
        for (int k = 0; k < 8; k++) begin
            do_req(32'h8034_5013 | (k << 5) | (k << 9), 1'b0, 2'd2, 32'h0, 1'b1);
            pa = port_addr;
            do_req(32'h8034_5013, 1'b0, 2'd2, 32'h0, 1'b1);
            pb = port_addr;
            chk(pa == pb, "R4 alias bits ignored", 32'(pa), 32'(pb));
        end

        // R10: request held while busy is ignored
        @(negedge clk);
        map_sel = 1'b0;
        @(negedge clk);
        req_valid = 1'b1; req_addr = 32'h8000_1111; req_write = 1'b0; req_size = 2'd2;
        @(negedge clk);
        req_addr = 32'h8000_2222;
        chk(port_addr == 16'h1111, "R10 first request issued", 32'(port_addr), 32'h1111);
        @(negedge clk);
        req_valid = 1'b0;
        chk(port_stb == 1'b0 && rsp_done == 1'b1, "R10 no strobe in response cycle",
            32'(port_stb), 32'd0);
        @(negedge clk);
        chk(port_stb == 1'b0 && rsp_done == 1'b0, "R10 busy request dropped",
            {30'd0, port_stb, rsp_done}, 32'd0);
        // miss held busy too
        req_valid = 1'b1; req_addr = 32'h1000_0000;
        @(negedge clk);
        req_addr = 32'h8000_3333;
        chk(rsp_done == 1'b1 && port_stb == 1'b0, "R10 miss answered", 32'(rsp_done), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk(port_stb == 1'b0, "R10 request during miss ignored", 32'(port_stb), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule